// File: doc/BRIEF.md
# Floating Compare Condition Code Unit

This block orders a floating source operand against a floating accumulator and returns the four condition flags (negative, zero, overflow, carry) that a floating status register takes after a compare. Operands use sign-magnitude encoding. Each operand arrives as two 32-bit words. The high word holds the sign in bit 31, an 8-bit exponent in bits 30:23 and the top of the fraction in bits 22:0. The low word extends the fraction in double format.

The caller presents both operands and the format flag, then raises `start` for one cycle. One clock later the unit pulses `done`, updates the flags and, when both operands compare as zero, raises `zero_wb` to ask that the accumulator be rewritten with the all-zero pattern. A value whose exponent is zero is treated as exact zero whatever its sign and fraction. The ordering comes from the raw bit patterns: the source sign gives a first guess at the negative flag, and that guess is inverted when the signs agree, the accumulator is nonzero and the source magnitude is the smaller.

Top module: `fpcmp_cc`

## Requirements
- R1: An operand whose exponent field (high word bits 30:23) is zero is treated as all-zero bits in both words before comparison, so a negative or fraction-bearing zero-exponent value equals +0.
- R2: When the cleaned operands are identical, the result is Z=1 with N=0, V=0 and C=0.
- R3: When the cleaned operands are identical and both are all-zero, `zero_wb` is 1 in the same cycle as `done`.
- R4: When the cleaned operands differ and their sign bits (bit 31) differ, N equals the source sign bit, and Z, V and C are 0.
- R5: When the cleaned operands differ and their signs agree, N is the source sign inverted if the accumulator high word is nonzero and the source magnitude {hi[30:0], lo} is below the accumulator's, and it is the source sign otherwise. N therefore reads 1 exactly when source < accumulator.
- R6: With `dbl`=0 the low words take no part, so operands that differ only in their low words compare equal.
- R7: With `dbl`=1 the low words take part in both the equality test and the magnitude test.
- R8: `done` is 1 exactly one clock after a cycle with `start`=1 and lasts one cycle. The flags keep their values until the next start.
- R9: After reset, `done`, `zero_wb` and all four flags are 0.
- R10: `zero_wb` stays 0 when the operands are equal but nonzero, and it stays 0 for every unequal pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compare the presented operands |
| dbl | input | 1 | 1 = double format (low words compared), 0 = single |
| src_hi | input | 32 | Source high word: sign, exponent, upper fraction |
| src_lo | input | 32 | Source low fraction word |
| acc_hi | input | 32 | Accumulator high word |
| acc_lo | input | 32 | Accumulator low fraction word |
| done | output | 1 | Result valid pulse, one cycle after start |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_v | output | 1 | Overflow flag |
| cc_c | output | 1 | Carry flag |
| zero_wb | output | 1 | Request to rewrite the accumulator with all-zero bits |

## Verification
Zero cleaning and the equality test take effect in the same cycle. A fraction-bearing or negative zero-exponent source against a clean +0 accumulator must therefore yield Z together with a writeback request, which can only happen if cleaning took place before equality was judged. The sweep forms every pairing of signs, edge exponents (0, 1, 0x80, 0xFF), edge fractions and low words in both formats. A model in the bench orders the pair numerically in sign-magnitude terms and gives the expected flags and writeback. That model is independent of the flip rule in the design.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int WORD_W  = 32;
    localparam int SIGN_IX = WORD_W - 1;
    localparam int EXP_MSB = 30;
    localparam int EXP_LSB = 23;
    localparam int MAG_W   = 2 * WORD_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } fp_opnd_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } fp_cc_t;

    function automatic logic exp_is_zero(input logic [WORD_W-1:0] hi);
        return hi[EXP_MSB:EXP_LSB] == '0;
    endfunction

    function automatic logic [MAG_W-1:0] magnitude(input fp_opnd_t op);
        return {op.hi[SIGN_IX-1:0], op.lo};
    endfunction

endpackage

// File: rtl/fpcmp_clean.sv
module fpcmp_clean
    import fpcmp_pkg::*;
(
    input  logic     dbl,
    input  fp_opnd_t raw,
    output fp_opnd_t clean
);
    always_comb begin
        clean = raw;
        if (!dbl)
            clean.lo = '0;
        if (exp_is_zero(raw.hi))
            clean = '0;
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fp_opnd_t src,
    input  fp_opnd_t acc,
    output logic     same,
    output logic     both_zero,
    output logic     sign_match,
    output logic     acc_hi_nz,
    output logic     src_mag_lt
);
    logic [MAG_W-1:0] src_mag;
    logic [MAG_W-1:0] acc_mag;

    always_comb begin
        src_mag    = magnitude(src);
        acc_mag    = magnitude(acc);
        same       = (src.hi == acc.hi) && (src.lo == acc.lo);
        both_zero  = same && (src == '0);
        sign_match = src.hi[SIGN_IX] == acc.hi[SIGN_IX];
        acc_hi_nz  = acc.hi != '0;
        src_mag_lt = src_mag < acc_mag;
    end
endmodule

// File: rtl/fpcmp_ccgen.sv
module fpcmp_ccgen
    import fpcmp_pkg::*;
(
    input  logic   same,
    input  logic   both_zero,
    input  logic   src_sign,
    input  logic   sign_match,
    input  logic   acc_hi_nz,
    input  logic   src_mag_lt,
    output fp_cc_t cc,
    output logic   wb
);
    logic flip;

    always_comb begin
        flip = sign_match && acc_hi_nz && src_mag_lt;
        cc   = '0;
        wb   = 1'b0;
        if (same) begin
            cc.z = 1'b1;
            wb   = both_zero;
        end else begin
            cc.n = src_sign ^ flip;
        end
    end
endmodule

// File: rtl/fpcmp_cc.sv
module fpcmp_cc
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dbl,
    input  logic [WORD_W-1:0] src_hi,
    input  logic [WORD_W-1:0] src_lo,
    input  logic [WORD_W-1:0] acc_hi,
    input  logic [WORD_W-1:0] acc_lo,
    output logic              done,
    output logic              cc_n,
    output logic              cc_z,
    output logic              cc_v,
    output logic              cc_c,
    output logic              zero_wb
);
    fp_opnd_t src_raw, acc_raw, src_c, acc_c;
    fp_cc_t   cc_next, cc_q;
    logic     same, both_zero, sign_match, acc_hi_nz, src_mag_lt, wb_next;

    assign src_raw = '{hi: src_hi, lo: src_lo};
    assign acc_raw = '{hi: acc_hi, lo: acc_lo};

    fpcmp_clean u_clean_src (.dbl(dbl), .raw(src_raw), .clean(src_c));
    fpcmp_clean u_clean_acc (.dbl(dbl), .raw(acc_raw), .clean(acc_c));

    fpcmp_order u_order (
        .src(src_c), .acc(acc_c), .same(same), .both_zero(both_zero),
        .sign_match(sign_match), .acc_hi_nz(acc_hi_nz), .src_mag_lt(src_mag_lt)
    );

    fpcmp_ccgen u_ccgen (
        .same(same), .both_zero(both_zero), .src_sign(src_c.hi[SIGN_IX]),
        .sign_match(sign_match), .acc_hi_nz(acc_hi_nz), .src_mag_lt(src_mag_lt),
        .cc(cc_next), .wb(wb_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            zero_wb <= 1'b0;
            cc_q    <= '0;
        end else begin
            done    <= start;
            zero_wb <= start && wb_next;
            if (start)
                cc_q <= cc_next;
        end
    end

    assign cc_n = cc_q.n;
    assign cc_z = cc_q.z;
    assign cc_v = cc_q.v;
    assign cc_c = cc_q.c;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> done); // R8
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst) done |-> $past(start)); // R8
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable({cc_n, cc_z, cc_v, cc_c})); // R8
    AST_Z_ALONE: assert property (@(posedge clk) disable iff (rst) cc_z |-> !cc_n && !cc_v && !cc_c); // R2
    AST_WB_NEEDS_Z: assert property (@(posedge clk) disable iff (rst) zero_wb |-> done && cc_z); // R3
    AST_N_FROM_SIGN: assert property (@(posedge clk) disable iff (rst)
        start && !same && !sign_match |=> cc_n == $past(src_c.hi[SIGN_IX])); // R4

endmodule

// File: tb/fpcmp_cc_bench.sv
module fpcmp_cc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dbl = 1'b0;
    logic [31:0] src_hi = '0, src_lo = '0, acc_hi = '0, acc_lo = '0;
    logic        done, cc_n, cc_z, cc_v, cc_c, zero_wb;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    fpcmp_cc u_fpcmp_cc (
        .clk(clk), .rst(rst), .start(start), .dbl(dbl),
        .src_hi(src_hi), .src_lo(src_lo), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .done(done), .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c),
        .zero_wb(zero_wb)
    );

    function automatic logic [31:0] mk_hi(input int s, input int e, input int f);
        logic [7:0]  ex;
        logic [22:0] fr;
        case (e)
            0: ex = 8'h00;
            1: ex = 8'h01;
            2: ex = 8'h80;
            default: ex = 8'hFF;
        endcase
        case (f)
            0: fr = 23'h0;
            1: fr = 23'h1;
            default: fr = 23'h7FFFFF;
        endcase
        return {s[0], ex, fr};
    endfunction

    function automatic logic [31:0] mk_lo(input int l);
        case (l)
            0: return 32'h0;
            1: return 32'h1;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    // expected {n,z,v,c,wb}: numeric sign-magnitude ordering
    function automatic logic [4:0] model(input logic [31:0] sh, sl, ah, al, input logic d);
        logic [63:0] s, a;
        logic [62:0] ms, ma;
        logic        ss, as_, lt;
        s = {sh, d ? sl : 32'h0};
        a = {ah, d ? al : 32'h0};
        if (sh[30:23] == 8'h0) s = '0;
        if (ah[30:23] == 8'h0) a = '0;
        if (s == a) return {1'b0, 1'b1, 1'b0, 1'b0, (s == 64'h0)};
        ss = s[63]; as_ = a[63]; ms = s[62:0]; ma = a[62:0];
        lt = (ss && !as_) || (!ss && !as_ && ms < ma) || (ss && as_ && ms > ma);
        return {lt, 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp_v);
        end
    endtask

    task automatic run_op(input logic [31:0] sh, sl, ah, al, input logic d, input string tag_in);
        logic [4:0] exp_v, got;
        string      tag;
        exp_v = model(sh, sl, ah, al, d);
        if (tag_in != "") tag = tag_in;
        else if (exp_v[0]) tag = "R3";
        else if (exp_v[3]) tag = "R2";
        else if (sh[31] == ah[31]) tag = "R5";
        else tag = "R4";
        @(negedge clk);
        src_hi = sh; src_lo = sl; acc_hi = ah; acc_lo = al; dbl = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        src_hi = ~sh; acc_hi = sh;
        got = {cc_n, cc_z, cc_v, cc_c, zero_wb};
        check({tag, " flags/writeback (R10)"}, got, exp_v);
        checks++;
        if (done !== 1'b1) begin
            errors++;
            $display("FAIL R8 done actual %b expected 1", done);
        end
        @(negedge clk);
        check("R8 hold after pulse", {cc_n, cc_z, cc_v, cc_c, done}, {exp_v[4:1], 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 reset state", {cc_n, cc_z, cc_v, cc_c, zero_wb}, 5'b0);
        checks++;
        if (done !== 1'b0) begin errors++; $display("FAIL R9 done actual %b expected 0", done); end

        // R1: negative, fraction-bearing zero-exponent source equals +0
        run_op(32'h807FFFFF, 32'h12345678, 32'h0, 32'h0, 1'b1, "R1");
        // R6: single mode ignores differing low words
        run_op(32'h40800000, 32'h0, 32'h40800000, 32'hFFFFFFFF, 1'b0, "R6");
        // R7: double mode, low word decides: src < acc positive
        run_op(32'h40800000, 32'h1, 32'h40800000, 32'h2, 1'b1, "R7");
        // R7: double mode, both negative, larger low word is smaller value
        run_op(32'hC0800000, 32'h2, 32'hC0800000, 32'h1, 1'b1, "R7");
        // R10: equal nonzero gives no writeback
        run_op(32'h3F800000, 32'h5, 32'h3F800000, 32'h5, 1'b1, "R10");
        // R4: negative source vs positive accumulator
        run_op(32'hBF800000, 32'h0, 32'h3F800000, 32'h0, 1'b0, "R4");
        // R5: both positive, acc zero -> no flip
        run_op(32'h3F800000, 32'h0, 32'h0, 32'h0, 1'b0, "R5");

        // near-exhaustive sweep
        for (int d = 0; d < 2; d++)
          for (int ss = 0; ss < 2; ss++)
            for (int se = 0; se < 4; se++)
              for (int sf = 0; sf < 3; sf++)
                for (int sl = 0; sl < 3; sl++)
                  for (int as_ = 0; as_ < 2; as_++)
                    for (int ae = 0; ae < 4; ae++)
                      for (int af = 0; af < 3; af++)
                        for (int al = 0; al < 3; al++)
                          run_op(mk_hi(ss, se, sf), mk_lo(sl),
                                 mk_hi(as_, ae, af), mk_lo(al), d[0], "");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule